// File: doc/BRIEF.md
# Buffered SPI Flash Command Master

This block sits on a simple word-addressed host bus and runs command transactions on an SPI serial flash. A small word buffer serves as both the outbound source and the inbound destination. The host loads the outbound bytes into the buffer and sets a send count and a receive count. Any write to the control word then starts a transfer. The block drops chip select and clocks out the send bytes. It then clocks in the receive bytes and stores each of them in the buffer.

Outbound bytes are packed two per buffer word, with the low byte going first. For a flash read this means the command and the top address byte sit in word 0, the middle and low address bytes sit in word 1, and the dummy byte sits in word 2. Inbound bytes are unpacked, one per word from word 0 upward, so they overwrite the command bytes.

Every accepted bus access returns a one-cycle acknowledge one clock after acceptance. The host holds its request until it sees that acknowledge. A write made while a transfer runs gets no acknowledge until the transfer ends. This lets the host wait for completion by issuing any write at all, for example clearing the send count.

Top module: `spi_buf_master`

## Requirements
- R1: After reset, chip select is high, SCK is low, no acknowledge is pending, and the send count, receive count and status all read 0x0000.
- R2: Buffer words sit at word addresses 0 to BUF_WORDS-1 and can be read and written. The send count sits at 0x100 and the receive count at 0x101. Each count reads back zero-extended. A written value above 2*BUF_WORDS for the send count, or above BUF_WORDS for the receive count, is stored as that limit.
- R3: A write to 0x102 starts a transfer, whatever the data value. Reading 0x102 returns 0xFFFF while a transfer runs and 0x0000 when idle. A read of 0x102 starts nothing.
- R4: A bus write issued during a transfer is acknowledged only after chip select has returned high, and it takes effect at that point. Reads of the status and count words are served during a transfer.
- R5: Send byte k comes from buffer word k/2. An even k takes bits 7:0 and an odd k takes bits 15:8. Each byte goes out MSB first on MOSI.
- R6: A send count of 1 with a receive count of 0 produces exactly 8 SCK rising edges, carrying bits 7:0 of word 0.
- R7: After the send bytes, received byte j is written to buffer word j in bits 7:0, with bits 15:8 cleared.
- R8: MOSI is 0 at every SCK rising edge of the receive phase.
- R9: The link uses SPI mode 0. SCK is low whenever chip select is high. The first rising edge comes exactly 2^DIV_LOG2 clocks after chip select falls. Chip select rises no sooner than 2^DIV_LOG2 clocks after the last falling edge. A transfer has 8*(send+receive) rising edges.
- R10: A start with both counts at 0 leaves chip select high and SCK still, and the status reads idle.
- R11: Buffer reads during a transfer are held until it ends. Addresses outside the map read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle acknowledge |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Two events can land in the same cycle. One is a held bus write becoming acceptable. The other is the engine finishing, that is, the status dropping and chip select rising. The bench provokes this by issuing a count write, or a buffer read, straight after each start. It judges the overlap in three ways: the acknowledge must come on a later cycle than the observed chip-select rise, the written count must read back afterwards, and the buffer read must return the byte that was just received rather than the stale command word. A status read placed between the start and the held write also checks that reads are still served while the transfer runs.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned OFS_SEND  = 32'h100;
  localparam int unsigned OFS_RECV  = 32'h101;
  localparam int unsigned OFS_CTRL  = 32'h102;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_LOW,
    ST_HIGH,
    ST_STORE,
    ST_ADV,
    ST_TAIL
  } eng_state_t;
endpackage

// File: rtl/spim_buffer.sv
`timescale 1ns/1ps
module spim_buffer #(
  parameter int unsigned WORDS = 16,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  // single port, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/spim_halfclk.sv
`timescale 1ns/1ps
module spim_halfclk #(
  parameter int unsigned DIV_LOG2 = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  generate
    if (DIV_LOG2 == 0) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      logic [DIV_LOG2-1:0] cnt;
      // counter restarts whenever the engine leaves a timed state
      always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
      end
      assign tick = run && (&cnt);
    end
  endgenerate
endmodule

// File: rtl/spim_engine.sv
`timescale 1ns/1ps
module spim_engine
  import spim_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 16,
  localparam int unsigned AW  = $clog2(BUF_WORDS),
  localparam int unsigned SCW = $clog2(2*BUF_WORDS+1),
  localparam int unsigned RCW = $clog2(BUF_WORDS+1),
  localparam int unsigned IW  = $clog2(3*BUF_WORDS+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SCW-1:0]    send_cnt,
  input  logic [RCW-1:0]    recv_cnt,
  input  logic              tick,
  output logic              timed,
  input  logic              miso,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n
);
  eng_state_t    state;
  logic [IW-1:0] byte_idx;
  logic [IW-1:0] total;
  logic [IW-1:0] rx_idx;
  logic [2:0]    bitcnt;
  logic [7:0]    shreg;
  logic [7:0]    tx_byte;
  logic          miso_q;
  logic          rx_phase;

  assign total    = IW'(send_cnt) + IW'(recv_cnt);
  assign rx_phase = byte_idx >= IW'(send_cnt);
  assign rx_idx   = byte_idx - IW'(send_cnt);
  assign tx_byte  = byte_idx[0] ? mem_rdata[15:8] : mem_rdata[7:0];

  assign mem_addr  = (state == ST_STORE) ? rx_idx[AW-1:0] : byte_idx[AW:1];
  assign mem_we    = (state == ST_STORE);
  assign mem_wdata = {8'h00, shreg};
  assign busy      = (state != ST_IDLE);
  assign timed     = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_TAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      byte_idx <= '0;
      bitcnt   <= '0;
      shreg    <= '0;
      miso_q   <= 1'b0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      cs_n     <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start && (total != '0)) begin
            byte_idx <= '0;
            state    <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_LOAD;
        ST_LOAD: begin
          shreg  <= rx_phase ? 8'h00 : tx_byte;
          mosi   <= rx_phase ? 1'b0  : tx_byte[7];
          bitcnt <= '0;
          cs_n   <= 1'b0;
          state  <= ST_LOW;
        end
        ST_LOW: begin
          if (tick) begin
            sck    <= 1'b1;
            miso_q <= miso;
            state  <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sck    <= 1'b0;
            shreg  <= {shreg[6:0], miso_q};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              state <= rx_phase ? ST_STORE : ST_ADV;
            end else begin
              mosi  <= rx_phase ? 1'b0 : shreg[6];
              state <= ST_LOW;
            end
          end
        end
        ST_STORE: state <= ST_ADV;
        ST_ADV: begin
          if (byte_idx + IW'(1) == total) begin
            mosi  <= 1'b0;
            state <= ST_TAIL;
          end else begin
            byte_idx <= byte_idx + IW'(1);
            state    <= ST_FETCH;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: serial clock never moves while the device is deselected
  a_r9_sck_low_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck) else $error("sck high with cs_n high");

  // R8: receive bits are clocked with a quiet data-out line
  a_r8_mosi_quiet_rx: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HIGH && rx_phase) |-> !mosi) else $error("mosi active in receive");

  // R1: an idle engine always leaves the device deselected
  a_r1_idle_deselected: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> cs_n) else $error("cs_n low while idle");

  // R7: stores land inside the requested receive window
  a_r7_store_in_window: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (rx_idx < IW'(recv_cnt))) else $error("store outside window");

  // R10: an empty start leaves the engine idle
  a_r10_empty_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && total == '0) |=> !busy) else $error("empty start ran");
endmodule

// File: rtl/spi_buf_master.sv
`timescale 1ns/1ps
module spi_buf_master
  import spim_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 16,
  parameter int unsigned DIV_LOG2  = 1,
  parameter int unsigned ADDR_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_ack,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  localparam int unsigned AW  = $clog2(BUF_WORDS);
  localparam int unsigned SCW = $clog2(2*BUF_WORDS+1);
  localparam int unsigned RCW = $clog2(BUF_WORDS+1);
  localparam int unsigned SEND_MAX = 2*BUF_WORDS;
  localparam int unsigned RECV_MAX = BUF_WORDS;

  logic [SCW-1:0]    send_cnt;
  logic [RCW-1:0]    recv_cnt;
  logic [WORD_W-1:0] rd_q;
  logic              rd_from_buf;
  logic              hit_buf, hit_send, hit_recv, hit_ctrl;
  logic              stall, accept, start;
  logic              eng_busy, eng_we, eng_timed, tick;
  logic [AW-1:0]     eng_addr, mem_addr;
  logic [WORD_W-1:0] eng_wdata, mem_wdata, mem_rdata;
  logic              mem_we;

  function automatic logic [SCW-1:0] clamp_send(input logic [15:0] v);
    if (v > 16'(SEND_MAX)) return SCW'(SEND_MAX);
    return v[SCW-1:0];
  endfunction

  function automatic logic [RCW-1:0] clamp_recv(input logic [15:0] v);
    if (v > 16'(RECV_MAX)) return RCW'(RECV_MAX);
    return v[RCW-1:0];
  endfunction

  assign hit_buf  = bus_addr < ADDR_W'(BUF_WORDS);
  assign hit_send = bus_addr == ADDR_W'(OFS_SEND);
  assign hit_recv = bus_addr == ADDR_W'(OFS_RECV);
  assign hit_ctrl = bus_addr == ADDR_W'(OFS_CTRL);

  // a running transfer owns the buffer port and holds every write
  assign stall  = eng_busy && (bus_we || hit_buf);
  assign accept = bus_req && !bus_ack && !stall;
  assign start  = accept && bus_we && hit_ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      send_cnt    <= '0;
      recv_cnt    <= '0;
      rd_q        <= '0;
      rd_from_buf <= 1'b0;
      bus_ack     <= 1'b0;
    end else begin
      bus_ack <= accept;
      if (accept) begin
        rd_from_buf <= hit_buf;
        if (bus_we) begin
          if (hit_send) send_cnt <= clamp_send(bus_wdata);
          if (hit_recv) recv_cnt <= clamp_recv(bus_wdata);
        end else begin
          if (hit_send)      rd_q <= WORD_W'(send_cnt);
          else if (hit_recv) rd_q <= WORD_W'(recv_cnt);
          else if (hit_ctrl) rd_q <= {WORD_W{eng_busy}};
          else               rd_q <= '0;
        end
      end
    end
  end

  assign bus_rdata = rd_from_buf ? mem_rdata : rd_q;

  assign mem_addr  = eng_busy ? eng_addr  : bus_addr[AW-1:0];
  assign mem_we    = eng_busy ? eng_we    : (accept && bus_we && hit_buf);
  assign mem_wdata = eng_busy ? eng_wdata : bus_wdata;

  spim_buffer #(.WORDS(BUF_WORDS), .DW(WORD_W)) u_buf (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  spim_halfclk #(.DIV_LOG2(DIV_LOG2)) u_half (
    .clk  (clk),
    .rst  (rst),
    .run  (eng_timed),
    .tick (tick)
  );

  spim_engine #(.BUF_WORDS(BUF_WORDS)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .send_cnt  (send_cnt),
    .recv_cnt  (recv_cnt),
    .tick      (tick),
    .timed     (eng_timed),
    .miso      (spi_miso),
    .mem_rdata (mem_rdata),
    .mem_addr  (eng_addr),
    .mem_we    (eng_we),
    .mem_wdata (eng_wdata),
    .busy      (eng_busy),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .cs_n      (spi_cs_n)
  );

  // R4: a write is only ever acknowledged when it was taken while idle
  a_r4_write_ack_idle: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && $past(bus_we)) |-> !$past(eng_busy)) else $error("write acked while busy");

  // R2: stored counts never exceed their limits
  a_r2_counts_limited: assert property (@(posedge clk) disable iff (rst)
    (send_cnt <= SCW'(SEND_MAX)) && (recv_cnt <= RCW'(RECV_MAX))) else $error("count over limit");

  // R11: buffer port never taken by the bus during a transfer
  a_r11_buf_port_owned: assert property (@(posedge clk) disable iff (rst)
    (accept && hit_buf) |-> !eng_busy) else $error("buffer access during transfer");
endmodule

// File: tb/sim_spi_buf_master.sv
`timescale 1ns/1ps
module sim_spi_buf_master;
  localparam int HALF = 2;   // 2**DIV_LOG2 with the default divider

  logic        clk, rst;
  logic        bus_req, bus_we;
  logic [9:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_ack;
  logic        spi_sck, spi_mosi, spi_miso, spi_cs_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  spi_buf_master u0 (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pat(input int b);
    return 8'(8'h5A + b * 29);
  endfunction

  // flash model and edge monitor, sampled mid-cycle
  logic       prev_sck = 1'b0, prev_cs = 1'b1;
  int         cs_fall_cyc = 0, first_rise_cyc = 0, last_fall_cyc = 0, cs_rise_cyc = 0;
  int         nbits = 0, sbyte = 0, sbit = 0, cs_falls = 0, bad_sck = 0;
  logic       got_first = 1'b0;
  logic [7:0] cap = 8'h00;
  logic [7:0] cap_bytes [64];

  initial spi_miso = 1'b0;

  always @(negedge clk) begin
    if (prev_cs && !spi_cs_n) begin
      cs_fall_cyc = cyc; cs_falls++; nbits = 0; sbyte = 0; sbit = 0;
      got_first = 1'b0; spi_miso = pat(0)[7];
    end
    if (!prev_cs && spi_cs_n) cs_rise_cyc = cyc;
    if (!prev_sck && spi_sck) begin
      if (spi_cs_n) bad_sck++;
      if (!got_first) begin first_rise_cyc = cyc; got_first = 1'b1; end
      cap = {cap[6:0], spi_mosi};
      nbits++;
    end
    if (prev_sck && !spi_sck) begin
      last_fall_cyc = cyc;
      sbit++;
      if (sbit == 8) begin
        if (sbyte < 64) cap_bytes[sbyte] = cap;
        sbyte++; sbit = 0;
      end
      spi_miso = pat(sbyte)[7 - sbit];
    end
    prev_sck = spi_sck;
    prev_cs  = spi_cs_n;
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic we, input logic [9:0] a, input logic [15:0] d,
                        output logic [15:0] q, output int ack_at);
    int w;
    w = 0;
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    do begin
      @(negedge clk);
      w++;
    end while (!bus_ack && w < 5000);
    if (!bus_ack) begin
      checks++; errors++;
      $display("FAIL bus timeout: actual no ack expected ack at %0h", a);
    end
    q = bus_rdata;
    ack_at = cyc;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  // {we, addr, wdata, expected, requirement}
  localparam int NV = 14;
  localparam logic [52:0] VEC [NV] = '{
    {1'b1, 16'h0100, 16'h0005, 16'h0000, 4'd2},  // R2 send count
    {1'b0, 16'h0100, 16'h0000, 16'h0005, 4'd2},  // R2
    {1'b1, 16'h0101, 16'h0010, 16'h0000, 4'd2},  // R2 receive count
    {1'b0, 16'h0101, 16'h0000, 16'h0010, 4'd2},  // R2
    {1'b1, 16'h0101, 16'h0028, 16'h0000, 4'd2},  // R2 over limit
    {1'b0, 16'h0101, 16'h0000, 16'h0010, 4'd2},  // R2 clamped to 16
    {1'b1, 16'h0100, 16'h0100, 16'h0000, 4'd2},  // R2 over limit
    {1'b0, 16'h0100, 16'h0000, 16'h0020, 4'd2},  // R2 clamped to 32
    {1'b1, 16'h0003, 16'hBEEF, 16'h0000, 4'd2},  // R2 buffer word
    {1'b0, 16'h0003, 16'h0000, 16'hBEEF, 4'd2},  // R2
    {1'b1, 16'h00F0, 16'h1234, 16'h0000, 4'd11}, // R11 unmapped write
    {1'b0, 16'h00F0, 16'h0000, 16'h0000, 4'd11}, // R11 unmapped reads 0
    {1'b0, 16'h0003, 16'h0000, 16'hBEEF, 4'd11}, // R11 no aliasing
    {1'b0, 16'h0102, 16'h0000, 16'h0000, 4'd3}   // R3 idle status
  };

  logic [15:0] q;
  int          ack_at;
  logic [52:0] v;
  int          bad;

  initial begin
    rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    check("R1 cs_n", spi_cs_n, 1);
    check("R1 sck", spi_sck, 0);
    check("R1 ack", bus_ack, 0);
    rst = 1'b0;
    bus_op(1'b0, 10'h100, 0, q, ack_at); check("R1 send count", q, 0);
    bus_op(1'b0, 10'h101, 0, q, ack_at); check("R1 recv count", q, 0);
    bus_op(1'b0, 10'h102, 0, q, ack_at); check("R1 status", q, 0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      bus_op(v[52], v[45:36], v[35:20], q, ack_at);
      if (!v[52]) check($sformatf("R%0d vector %0d", v[3:0], i), q, v[19:4]);
    end

    // R6: single command byte
    bus_op(1'b1, 10'h000, 16'h77AB, q, ack_at);
    bus_op(1'b1, 10'h100, 16'd1, q, ack_at);
    bus_op(1'b1, 10'h101, 16'd0, q, ack_at);
    bus_op(1'b1, 10'h102, 16'h5A5A, q, ack_at);
    bus_op(1'b0, 10'h102, 0, q, ack_at); check("R3 busy status", q, 16'hFFFF);
    bus_op(1'b1, 10'h100, 16'd0, q, ack_at);
    check("R4 held write after cs rise", ack_at > cs_rise_cyc, 1);
    check("R6 edge count", nbits, 8);
    check("R6 byte", cap_bytes[0], 8'hAB);
    check("R9 lead", first_rise_cyc - cs_fall_cyc, HALF);
    check("R9 trail", (cs_rise_cyc - last_fall_cyc) >= HALF, 1);
    bus_op(1'b0, 10'h100, 0, q, ack_at); check("R4 held write applied", q, 0);

    // R5 R7 R8: fast read, 5 out and 16 in
    bus_op(1'b1, 10'h000, 16'h120B, q, ack_at);
    bus_op(1'b1, 10'h001, 16'h5634, q, ack_at);
    bus_op(1'b1, 10'h002, 16'h0000, q, ack_at);
    for (int i = 3; i < 16; i++) bus_op(1'b1, 10'(i), 16'hDEAD, q, ack_at);
    bus_op(1'b1, 10'h100, 16'd5, q, ack_at);
    bus_op(1'b1, 10'h101, 16'd16, q, ack_at);
    bus_op(1'b1, 10'h102, 16'h0000, q, ack_at);
    bus_op(1'b0, 10'h102, 0, q, ack_at); check("R3 busy status", q, 16'hFFFF);
    bus_op(1'b0, 10'h101, 0, q, ack_at);
    check("R4 count read served", q, 16'd16);
    check("R4 read during transfer", spi_cs_n, 0);
    bus_op(1'b1, 10'h100, 16'd0, q, ack_at);
    check("R4 held write after cs rise", ack_at > cs_rise_cyc, 1);
    check("R5 byte0", cap_bytes[0], 8'h0B);
    check("R5 byte1", cap_bytes[1], 8'h12);
    check("R5 byte2", cap_bytes[2], 8'h34);
    check("R5 byte3", cap_bytes[3], 8'h56);
    check("R5 byte4", cap_bytes[4], 8'h00);
    bad = 0;
    for (int i = 5; i < 21; i++) if (cap_bytes[i] != 8'h00) bad++;
    check("R8 quiet receive bytes", bad, 0);
    check("R9 edge count", nbits, 168);
    for (int j = 0; j < 16; j++) begin
      bus_op(1'b0, 10'(j), 0, q, ack_at);
      check($sformatf("R7 word %0d", j), q, {8'h00, pat(5 + j)});
    end

    // R11: buffer read held until the transfer ends
    bus_op(1'b1, 10'h000, 16'h009F, q, ack_at);
    bus_op(1'b1, 10'h100, 16'd1, q, ack_at);
    bus_op(1'b1, 10'h101, 16'd1, q, ack_at);
    bus_op(1'b1, 10'h102, 16'hBEEF, q, ack_at);
    bus_op(1'b0, 10'h000, 0, q, ack_at);
    check("R11 read held", ack_at > cs_rise_cyc, 1);
    check("R11 fresh byte", q, {8'h00, pat(1)});
    check("R5 single byte", cap_bytes[0], 8'h9F);

    // R10: empty start
    bus_op(1'b1, 10'h100, 16'd0, q, ack_at);
    bus_op(1'b1, 10'h101, 16'd0, q, ack_at);
    bad = cs_falls;
    bus_op(1'b1, 10'h102, 16'h0001, q, ack_at);
    bus_op(1'b0, 10'h102, 0, q, ack_at); check("R10 status idle", q, 0);
    repeat (20) @(negedge clk);
    check("R10 no select", cs_falls, bad);
    check("R10 cs high", spi_cs_n, 1);
    check("R9 no sck while deselected", bad_sck, 0);

    finish_run();
  end
endmodule